// File: doc/BRIEF.md
# Paged Buffer Access Pointer

This block gives a host processor a narrow window into a packet buffer RAM. The host selects a page and an offset within that page through two small registers. It then moves data in or out of the buffer through one data register. The concatenation of page and offset forms the RAM address. After each data-register access the pointer can step forward on its own, so that a whole packet streams through a single register location.

When a step carries out of the top of the offset, one of two things happens, as set by a control bit: the pointer returns to offset zero of the same page, or it moves to offset zero of the following page. A new page number is held in a staging register. It reaches the RAM address only when the offset register is next written, so the two halves of the pointer always change together.

In read direction the block fetches the addressed word ahead of time. A host read of the data register therefore completes without a wait state.

Top module: `bufptr_port`

## Requirements
- R1: The control register sits at host offset 4. Its fields are: bit 7 direction (1 = host reads the buffer, 0 = host writes it), bit 6 auto-step enable, bit 5 carry mode, and bits 4:0 the page. A read returns the three control bits and the committed page, with bits 15:8 and any unused page bits read as zero.
- R2: After reset the control bits, the staged page, the committed page and the offset are all zero, and neither RAM strobe is active.
- R3: A page written to the control register has no effect on `ram_addr` until the offset register (host offset 5) is written. That write commits the staged page and loads the offset together.
- R4: Page bits above the number of pages, RAM_BYTES/PAGE_BYTES, are dropped. With the defaults only bits 2:0 are kept.
- R5: With auto-step on, a narrow bus (BUS16=0) and `cfg_word_mode`=0, each data-register access (host offset 7) advances the offset by 1.
- R6: With auto-step on and either `cfg_word_mode`=1 or BUS16=1, each data access advances the offset by 2.
- R7: With auto-step off, a data access leaves page and offset unchanged.
- R8: When a step carries out of the offset and the carry-mode bit is 0, the offset becomes 0 and the page is unchanged.
- R9: When a step carries out and the carry-mode bit is 1, the offset becomes 0 and the page increments. From the highest page it goes to page 0.
- R10: In write direction, a host write to the data register asserts `ram_wr` in the same cycle, with `ram_addr` equal to {page, offset} and `ram_wdata` equal to `host_wdata`. In read direction, a host write to the data register never asserts `ram_wr`.
- R11: In read direction, after an offset write or a step, `ram_rd` pulses for the new address. The returned word is readable at host offset 7 from the second cycle after that edge.
- R12: Accesses to the control or offset registers never step the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word_mode | input | 1 | 1 = two-byte step on a narrow bus |
| host_addr | input | 3 | Host register select |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | HOST_W | Host write data |
| host_rdata | output | HOST_W | Host read data, combinational from host_addr |
| ram_addr | output | RA_W | Buffer address {page, offset} |
| ram_wr | output | 1 | Buffer write strobe |
| ram_rd | output | 1 | Buffer read (prefetch) strobe |
| ram_wdata | output | HOST_W | Buffer write data |
| ram_rdata | input | HOST_W | Buffer read data, one cycle after ram_rd |

## Verification
The assertions assume that the host raises at most one of `host_wr` and `host_rd` in any cycle, and that it issues one register access per cycle. Under that assumption, a control write and a data step can never coincide, and a prefetch can never overlap a buffer write. The stimulus drives every access as a single-cycle strobe from a task, with the strobe set and cleared on falling edges. Before each read of the data register, the bench also waits out the two-cycle prefetch latency.

// File: rtl/bufptr_pkg.sv
`timescale 1ns/1ps
package bufptr_pkg;
    localparam logic [2:0] REG_CTRL = 3'h4;
    localparam logic [2:0] REG_OFFS = 3'h5;
    localparam logic [2:0] REG_DATA = 3'h7;
    localparam int CB_DIR = 7;
    localparam int CB_INC = 6;
    localparam int CB_NXT = 5;
endpackage

// File: rtl/bufptr_step.sv
`timescale 1ns/1ps
module bufptr_step #(
    parameter int OFF_W = 8,
    parameter int PG_W  = 3
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [PG_W-1:0]  page_i,
    input  logic             wide_i,
    input  logic             next_pg_i,
    output logic [OFF_W-1:0] off_o,
    output logic [PG_W-1:0]  page_o,
    output logic             carry_o
);
    logic [OFF_W:0] inc;
    logic [OFF_W:0] sum;

    always_comb begin
        inc     = wide_i ? (OFF_W+1)'(2) : (OFF_W+1)'(1);
        sum     = {1'b0, off_i} + inc;
        carry_o = sum[OFF_W];
        if (carry_o) begin
            off_o  = '0;
            page_o = next_pg_i ? page_i + PG_W'(1) : page_i;
        end else begin
            off_o  = sum[OFF_W-1:0];
            page_o = page_i;
        end
    end
endmodule

// File: rtl/bufptr_fetch.sv
`timescale 1ns/1ps
module bufptr_fetch #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] ram_rdata_i,
    output logic          ram_rd_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          pend;
        logic          land;
        logic [DW-1:0] data;
    } fst_t;

    fst_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.pend = start_i;
        f_d.land = f_q.pend;
        if (f_q.land) f_d.data = ram_rdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign ram_rd_o = f_q.pend;
    assign data_o   = f_q.data;

    // R11: captured word arrives exactly one cycle after the RAM strobe
    assert_capture_after_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_o |=> f_q.land);
endmodule

// File: rtl/bufptr_port.sv
`timescale 1ns/1ps
module bufptr_port
    import bufptr_pkg::*;
#(
    parameter int RAM_BYTES  = 2048,
    parameter int PAGE_BYTES = 256,
    parameter int BUS16      = 0,
    parameter int HOST_W     = 16,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int NPAGES = RAM_BYTES / PAGE_BYTES,
    localparam int PG_W   = $clog2(NPAGES),
    localparam int RA_W   = OFF_W + PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_word_mode,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic [RA_W-1:0]   ram_addr,
    output logic              ram_wr,
    output logic              ram_rd,
    output logic [HOST_W-1:0] ram_wdata,
    input  logic [HOST_W-1:0] ram_rdata
);
    typedef struct packed {
        logic             rd_mode;
        logic             auto_inc;
        logic             next_pg;
        logic [PG_W-1:0]  stage;
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] off;
    } pst_t;

    pst_t s_d, s_q;

    logic             ctrl_wr, offs_wr, data_acc, wide, fetch_go;
    logic [OFF_W-1:0] step_off;
    logic [PG_W-1:0]  step_page;
    logic             step_carry;
    logic [HOST_W-1:0] fetched;

    assign ctrl_wr  = host_wr && (host_addr == REG_CTRL);
    assign offs_wr  = host_wr && (host_addr == REG_OFFS);
    assign data_acc = (host_wr || host_rd) && (host_addr == REG_DATA);
    assign wide     = (BUS16 != 0) || cfg_word_mode;

    bufptr_step #(.OFF_W(OFF_W), .PG_W(PG_W)) u_step (
        .off_i     (s_q.off),
        .page_i    (s_q.page),
        .wide_i    (wide),
        .next_pg_i (s_q.next_pg),
        .off_o     (step_off),
        .page_o    (step_page),
        .carry_o   (step_carry)
    );

    always_comb begin
        s_d      = s_q;
        fetch_go = 1'b0;
        if (ctrl_wr) begin
            s_d.rd_mode  = host_wdata[CB_DIR];
            s_d.auto_inc = host_wdata[CB_INC];
            s_d.next_pg  = host_wdata[CB_NXT];
            s_d.stage    = host_wdata[PG_W-1:0];
        end
        if (offs_wr) begin
            s_d.off  = host_wdata[OFF_W-1:0];
            s_d.page = s_q.stage;
            fetch_go = s_q.rd_mode;
        end
        if (data_acc && s_q.auto_inc) begin
            s_d.off  = step_off;
            s_d.page = step_page;
            fetch_go = s_q.rd_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    bufptr_fetch #(.DW(HOST_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (fetch_go),
        .ram_rdata_i (ram_rdata),
        .ram_rd_o    (ram_rd),
        .data_o      (fetched)
    );

    assign ram_addr  = {s_q.page, s_q.off};
    assign ram_wr    = data_acc && host_wr && !s_q.rd_mode;
    assign ram_wdata = host_wdata;

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            REG_CTRL: begin
                host_rdata[CB_DIR]     = s_q.rd_mode;
                host_rdata[CB_INC]     = s_q.auto_inc;
                host_rdata[CB_NXT]     = s_q.next_pg;
                host_rdata[PG_W-1:0]   = s_q.page;
            end
            REG_OFFS: host_rdata[OFF_W-1:0] = s_q.off;
            REG_DATA: host_rdata = fetched;
            default:  host_rdata = '0;
        endcase
    end

    // Input assumption: one strobe per cycle
    assert_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));

    // R3: a control write alone leaves the committed page alone
    assert_page_staged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> $stable(s_q.page));

    // R7: no stepping when auto-step is off
    assert_noinc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !s_q.auto_inc) |=> $stable(ram_addr));

    // R5: an auto-step always moves the pointer
    assert_step_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && s_q.auto_inc) |=> (ram_addr != $past(ram_addr)));

    // R8: same-page carry mode never touches the page
    assert_same_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && s_q.auto_inc && !s_q.next_pg) |=> $stable(s_q.page));

    // R12: non-data accesses other than an offset write keep the offset
    assert_other_regs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || host_rd) && (host_addr != REG_DATA) && !offs_wr) |=> $stable(s_q.off));

    // R10: prefetch and buffer write never overlap
    assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_rd, ram_wr}));
endmodule

// File: tb/bufptr_port_tb.sv
`timescale 1ns/1ps
module bufptr_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_word_mode = 1'b0;
    logic [2:0]  host_addr = 3'h0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic [10:0] ram_addr;
    logic        ram_wr, ram_rd;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = 16'h0;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    bufptr_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_word_mode(cfg_word_mode),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ram_addr(ram_addr), .ram_wr(ram_wr), .ram_rd(ram_rd),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    logic [15:0] mem [0:2047];
    logic        wv  [0:2047];

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 7) ^ 16'hC300;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) wv[i] <= 1'b0;
        end else begin
            if (ram_wr) begin
                mem[ram_addr] <= ram_wdata;
                wv[ram_addr]  <= 1'b1;
            end
            if (ram_rd) ram_rdata <= wv[ram_addr] ? mem[ram_addr] : pat(int'(ram_addr));
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic dwrite(input string req, input logic [15:0] d, input logic [10:0] exp_addr);
        @(negedge clk);
        host_addr = 3'h7; host_wdata = d; host_wr = 1'b1;
        #1;
        chk({req, " ram_wr"}, 32'(ram_wr), 32'd1);
        chk({req, " ram_addr"}, 32'(ram_addr), 32'(exp_addr));
        chk({req, " ram_wdata"}, 32'(ram_wdata), 32'(d));
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R2 ram_addr", 32'(ram_addr), 32'h0);
        chk("R2 strobes", 32'({ram_rd, ram_wr}), 32'h0);
        hr(3'h4, v); chk("R2 ctrl", 32'(v), 32'h0);
        hr(3'h5, v); chk("R2 offs", 32'(v), 32'h0);
    endtask

    task automatic t_stage;
        logic [15:0] v;
        hw(3'h4, 16'hFFE5);
        hr(3'h4, v); chk("R1 R3 ctrl before commit", 32'(v), 32'h00E0);
        chk("R3 addr before commit", 32'(ram_addr), 32'h000);
        hw(3'h5, 16'h0010);
        hr(3'h4, v); chk("R1 ctrl after commit", 32'(v), 32'h00E5);
        chk("R3 addr after commit", 32'(ram_addr), 32'h510);
    endtask

    task automatic t_mask;
        logic [15:0] v;
        hw(3'h4, 16'h001F);
        hw(3'h5, 16'h0000);
        chk("R4 masked page addr", 32'(ram_addr), 32'h700);
        hr(3'h4, v); chk("R4 masked page read", 32'(v), 32'h0007);
    endtask

    task automatic t_write_step;
        cfg_word_mode = 1'b0;
        hw(3'h4, 16'h0042);
        hw(3'h5, 16'h0020);
        dwrite("R10", 16'hABCD, 11'h220);
        chk("R5 step by 1", 32'(ram_addr), 32'h221);
        chk("R10 stored", 32'(mem[11'h220]), 32'hABCD);
        cfg_word_mode = 1'b1;
        dwrite("R10 wide", 16'h1234, 11'h221);
        chk("R6 step by 2", 32'(ram_addr), 32'h223);
        cfg_word_mode = 1'b0;
    endtask

    task automatic t_noinc;
        hw(3'h4, 16'h0002);
        hw(3'h5, 16'h0030);
        dwrite("R7 first", 16'h1111, 11'h230);
        dwrite("R7 second", 16'h2222, 11'h230);
        chk("R7 pointer held", 32'(ram_addr), 32'h230);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        hw(3'h4, 16'h0043);
        hw(3'h5, 16'h00FF);
        dwrite("R8", 16'h0A0A, 11'h3FF);
        chk("R8 same page wrap", 32'(ram_addr), 32'h300);
        cfg_word_mode = 1'b1;
        hw(3'h5, 16'h00FE);
        dwrite("R8 wide", 16'h0B0B, 11'h3FE);
        chk("R8 wide wrap", 32'(ram_addr), 32'h300);
        cfg_word_mode = 1'b0;
        hw(3'h4, 16'h0063);
        hw(3'h5, 16'h00FF);
        dwrite("R9", 16'h0C0C, 11'h3FF);
        chk("R9 next page", 32'(ram_addr), 32'h400);
        hr(3'h4, v); chk("R9 page readback", 32'(v), 32'h0064);
        hw(3'h4, 16'h0067);
        hw(3'h5, 16'h00FF);
        dwrite("R9 top", 16'h0D0D, 11'h7FF);
        chk("R9 top page to 0", 32'(ram_addr), 32'h000);
    endtask

    task automatic t_other;
        logic [15:0] v;
        hw(3'h4, 16'h0044);
        hw(3'h5, 16'h0010);
        hr(3'h4, v);
        hr(3'h5, v); chk("R12 offs read", 32'(v), 32'h0010);
        hw(3'h4, 16'h0046);
        hr(3'h0, v);
        chk("R12 pointer unchanged", 32'(ram_addr), 32'h410);
    endtask

    task automatic t_read;
        logic [15:0] v;
        hw(3'h4, 16'h00C1);
        hw(3'h5, 16'h0008);
        chk("R11 prefetch strobe", 32'(ram_rd), 32'd1);
        repeat (2) @(negedge clk);
        hr(3'h7, v); chk("R11 first word", 32'(v), 32'(pat(16'h108)));
        chk("R11 R5 read step", 32'(ram_addr), 32'h109);
        repeat (2) @(negedge clk);
        hr(3'h7, v); chk("R11 second word", 32'(v), 32'(pat(16'h109)));
        repeat (2) @(negedge clk);
        @(negedge clk);
        host_addr = 3'h7; host_wdata = 16'hDEAD; host_wr = 1'b1;
        #1 chk("R10 no write in read dir", 32'(ram_wr), 32'd0);
        @(negedge clk);
        host_wr = 1'b0;
        chk("R10 buffer untouched", 32'(wv[11'h10A]), 32'd0);
        repeat (2) @(negedge clk);
        hr(3'h7, v); chk("R11 after ignored write", 32'(v), 32'(pat(16'h10B)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stage();
        t_mask();
        t_write_step();
        t_noinc();
        t_wrap();
        t_other();
        t_read();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule